// File: doc/BRIEF.md
# Non-blocking two-phase ZQ calibration scheduler

This block runs periodic impedance calibration for a low-power DRAM without holding off the memory controller for the whole calibration time. Each calibration takes two multipurpose commands. A start command begins the measurement inside the device. A latch command, issued later, applies the new impedance values. A trigger pulse begins a cycle. The block then asks the command-bus arbiter for the bus and issues the start command once granted. It releases the bus again while it counts the start-to-latch interval, so normal traffic keeps flowing during that interval.

When the interval has run out, the block asks for the bus again and issues the latch command. It then holds a lock output for the post-latch settling time, so the arbiter lets no other command through. Both waits are derived from the clock period and rounded up to whole cycles. The post-latch wait never drops below 8 cycles. Triggers that arrive while a calibration is running are remembered and start one more calibration afterwards.

Top module: `zq_cal_sched`

## Requirements
- R1: `cmd_vld_o` is high only in a cycle where both `req_o` and `gnt_i` are high, and it is high in every such cycle.
- R2: `req_o` is low in the cycle after a command issues.
- R3: The latch command issues no earlier than START_CYC+1 cycles after the start command. `req_o` for the latch rises only after that wait. A late grant lengthens the gap and never shortens it.
- R4: After the latch command, `lock_o` is high for exactly LOCK_CYC cycles, starting the next cycle. `req_o` stays low while `lock_o` is high.
- R5: The command value on `cmd_op_o` (the operand driven on address bits [6:0], bank 0) is 7'b1001111 for the start command and 7'b1010001 for the latch command.
- R6: `busy_o` rises the cycle after the start command and falls the cycle after the last lock cycle.
- R7: A trigger seen while `busy_o` is high is kept pending. It does not disturb the running calibration. After the block returns to idle, it starts exactly one more calibration, however many triggers arrived.
- R8: A trigger that arrives while a start request is still waiting for its grant is merged into that request and causes no extra calibration.
- R9: START_CYC = ceil(T_ZQCAL_PS / T_CK_PS) and LOCK_CYC = max(8, ceil(T_ZQLAT_PS / T_CK_PS)). With the defaults (10 ns clock, 1 us, 30 ns) these are 101 cycles of gap with an immediate grant and 8 lock cycles.
- R10: During and after reset, with no trigger, `req_o`, `cmd_vld_o`, `busy_o` and `lock_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Periodic calibration trigger pulse |
| req_o | output | 1 | Bus request to the command arbiter |
| gnt_i | input | 1 | Bus grant from the arbiter |
| cmd_vld_o | output | 1 | Multipurpose command issued this cycle |
| cmd_op_o | output | 7 | Operand of the issued command (address bits [6:0]) |
| busy_o | output | 1 | Calibration in progress |
| lock_o | output | 1 | Post-latch settling: arbiter must issue nothing |

## Verification
The embedded assertions check on every cycle that issue coincides with request and grant, that the request drops after issue, that the start-to-latch gap never falls below its minimum, that lock follows the latch without a request, and that busy rises only after a start command. Only the bench scenarios show the pending and merged trigger behaviour, the exact lengths of the gap and the lock, and the stretching of the interval under sparse grants. These are compared against a behavioural model on every clock.

// File: rtl/zq_cal_sched.sv
module zq_cal_sched #(
  parameter int T_CK_PS    = 10000,
  parameter int T_ZQCAL_PS = 1000000,
  parameter int T_ZQLAT_PS = 30000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trig_i,
  output logic       req_o,
  input  logic       gnt_i,
  output logic       cmd_vld_o,
  output logic [6:0] cmd_op_o,
  output logic       busy_o,
  output logic       lock_o
);
  localparam int START_CYC = (T_ZQCAL_PS + T_CK_PS - 1) / T_CK_PS;
  localparam int LAT_RAW   = (T_ZQLAT_PS + T_CK_PS - 1) / T_CK_PS;
  localparam int LOCK_CYC  = (LAT_RAW > 8) ? LAT_RAW : 8;
  localparam int MAXW      = (START_CYC > LOCK_CYC) ? START_CYC : LOCK_CYC;
  localparam int CW        = $clog2(MAXW + 2) + 1;
  localparam logic [6:0] OP_START = 7'b1001111;
  localparam logic [6:0] OP_LATCH = 7'b1010001;

  typedef enum logic [2:0] {IDLE, ASK_S, WAIT_C, ASK_L, SETTLE} st_t;
  st_t st;
  logic [CW-1:0] cnt;
  logic pend;

  assign req_o     = (st == ASK_S) || (st == ASK_L);
  assign cmd_vld_o = req_o && gnt_i;
  assign cmd_op_o  = (st == ASK_L) ? OP_LATCH : OP_START;
  assign busy_o    = (st == WAIT_C) || (st == ASK_L) || (st == SETTLE);
  assign lock_o    = (st == SETTLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= IDLE;
      cnt  <= '0;
      pend <= 1'b0;
    end else begin
      if (trig_i && busy_o) pend <= 1'b1;
      unique case (st)
        IDLE: if (trig_i || pend) begin
          st   <= ASK_S;
          pend <= 1'b0;
        end
        ASK_S: if (gnt_i) begin
          st  <= WAIT_C;
          cnt <= CW'(START_CYC - 1);
        end
        WAIT_C: if (cnt == '0) st <= ASK_L;
                else cnt <= cnt - 1'b1;
        ASK_L: if (gnt_i) begin
          st  <= SETTLE;
          cnt <= CW'(LOCK_CYC - 1);
        end
        SETTLE: if (cnt == '0) st <= IDLE;
                else cnt <= cnt - 1'b1;
        default: st <= IDLE;
      endcase
    end
  end

  logic [CW-1:0] gap;
  wire start_fire = cmd_vld_o && (cmd_op_o == OP_START);
  wire latch_fire = cmd_vld_o && (cmd_op_o == OP_LATCH);
  always_ff @(posedge clk) begin
    if (!rst_n) gap <= '0;
    else if (start_fire) gap <= CW'(1);
    else if (gap <= CW'(START_CYC + 1)) gap <= gap + 1'b1;
  end

  // R1
  issue_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld_o |-> (req_o && gnt_i));
  // R2
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld_o |=> !req_o);
  // R3
  min_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch_fire |-> (gap >= CW'(START_CYC + 1)));
  // R4
  lock_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch_fire |=> lock_o);
  // R4
  lock_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_o |-> !req_o);
  // R6
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_fire));
endmodule

// File: tb/zq_cal_sched_bench.sv
module zq_cal_sched_bench;
  localparam int SW = 100;
  localparam int LW = 8;
  logic clk = 0, rst_n = 0, trig = 0, gnt = 0;
  logic req, cmd_vld, busy, lock;
  logic [6:0] op;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  zq_cal_sched u_zq_cal_sched (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .req_o(req), .gnt_i(gnt),
    .cmd_vld_o(cmd_vld), .cmd_op_o(op), .busy_o(busy), .lock_o(lock));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic stim_gnt(int c);
    if (c < 400) return 1'b1;
    if (c < 900) return (c % 7) == 0;
    if (c < 1000) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic stim_trig(int c);
    return c == 5 || c == 50 || c == 60 || c == 410 || c == 411 || c == 905;
  endfunction

  int ph = 0, t0 = 0, t1 = 0, nph;
  int last_start = -1, locks = 0, n_starts = 0;
  bit pend = 0, first = 1;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 req", req, 0); chk("R10 cmd_vld", cmd_vld, 0);
    chk("R10 busy", busy, 0); chk("R10 lock", lock, 0);
    rst_n = 1;
    for (int c = 0; c < 1400; c++) begin
      trig = stim_trig(c);
      gnt  = stim_gnt(c);
      #1;
      chk("R2 req", req, (ph == 1 || ph == 3));
      chk("R1 cmd_vld", cmd_vld, (ph == 1 || ph == 3) && gnt);
      if (cmd_vld) chk("R5 op", op, ph == 3 ? 7'b1010001 : 7'b1001111);
      chk("R6 busy", busy, (ph >= 2));
      chk("R4 lock", lock, (ph == 4));
      if (lock) locks++;
      if (cmd_vld && op == 7'b1001111) begin
        if (last_start >= 0 && !first) chk("R4 lock count", locks, LW);
        last_start = c; locks = 0; n_starts++;
      end
      if (cmd_vld && op == 7'b1010001) begin
        chk("R3 gap", (c - last_start) >= SW + 1, 1);
        if (first) begin chk("R9 gap", c - last_start, SW + 1); first = 0; end
      end
      nph = ph;
      case (ph)
        0: if (trig || pend) begin nph = 1; pend = 0; end
        1: if (gnt) begin nph = 2; t0 = c; end
        2: if (c == t0 + SW) nph = 3;
        3: if (gnt) begin nph = 4; t1 = c; end
        4: if (c == t1 + LW) nph = 0;
        default: nph = 0;
      endcase
      if (trig && ph >= 2) pend = 1;
      ph = nph;
      @(negedge clk);
    end
    chk("R4 lock count final", locks, LW);
    chk("R7 R8 calibrations", n_starts, 4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule